// File: doc/BRIEF.md
# Double-Buffer Subaddress Status Controller

This block holds the per-subaddress status and control word of a command/response serial-bus remote terminal whose transmit data can be double-buffered. For every subaddress it keeps a host-written enable and stop-request pair, a terminal-owned acknowledge, a buffer-select bit, a broadcast flag and an activity flag. The protocol engine reports the start of each command (subaddress, transmit direction, broadcast) and its completion (done, with error, illegal and busy qualifiers). The block answers with `ptr_b`, the data pointer the current message must use: 0 for pointer A, 1 for pointer B.

The block has two kinds of state machine. A message sequencer has states MSG_IDLE and MSG_BUSY. A start moves it from MSG_IDLE to MSG_BUSY and latches the subaddress. A done moves it from MSG_BUSY back to MSG_IDLE. A start that arrives in MSG_BUSY, or a done that arrives in MSG_IDLE, is ignored. Each subaddress also has an alternation state machine with states SA_OFF, SA_RUN and SA_HALT, and its acknowledge bit is high only in SA_RUN. The transitions are:
- SA_OFF to SA_RUN when the enable bit is set and the stop bit is clear.
- SA_OFF to SA_HALT when both the enable and stop bits are set.
- SA_RUN to SA_HALT on a stop request.
- SA_HALT to SA_RUN when the stop request is withdrawn.
- SA_RUN or SA_HALT to SA_OFF when the enable bit is cleared.

All of these transitions happen only in a quiet cycle. A quiet cycle is one in which the sequencer is in MSG_IDLE and no start is present.

Top module: `pp_desc_ctrl`

## Requirements
- R1: After master reset every control word reads 0 and `ptr_b` is 0. Word layout: bit0 enable, bit1 stop request, bit4 acknowledge, bit5 buffer select, bit6 broadcast, bit7 activity. All other bits read 0.
- R2: Every accepted completion sets the activity bit (bit7) of the message's subaddress. This holds for any outcome and for either direction.
- R3: A host read returns the word and then clears its activity bit. If a completion for the same subaddress falls in the same cycle as the read, the read returns the old word and the activity bit stays set.
- R4: The select bit (bit5) inverts after a transmit completion that is free of error, illegal and busy, but only while the subaddress is in SA_RUN. The next message then gets the other pointer on `ptr_b`.
- R5: The select bit does not change after a completion flagged error, illegal or busy. It also does not change after a receive completion.
- R6: With enable=1 and stop=0 the acknowledge bit (bit4) reads 1. Setting stop makes it read 0. Clearing stop makes it read 1 again.
- R7: The acknowledge bit does not change while a message is in progress. A stop request written during a message takes effect only after the done.
- R8: With enable=1 and the acknowledge bit at 0, `ptr_b` equals the select bit and completions leave the select bit unchanged.
- R9: A broadcast transmit start sets the broadcast bit (bit6) of its subaddress, unless `bcast_disable` is 1.
- R10: When enable is 0, `ptr_b` is 0 whatever the select bit holds.
- R11: Host writes change only bit0 and bit1. Written values in bits 2 to 7 are ignored.
- R12: `soft_rst` returns every word and `ptr_b` to the reset state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous master reset, active low |
| soft_rst | input | 1 | Synchronous software reset |
| bcast_disable | input | 1 | Broadcast recognition off |
| msg_start | input | 1 | Command accepted, one-cycle pulse |
| msg_sa | input | SA_W | Subaddress of the starting command |
| msg_tx | input | 1 | Starting command is a transmit |
| msg_bcast | input | 1 | Starting command is broadcast transmit |
| msg_done | input | 1 | Message completed, one-cycle pulse |
| msg_err | input | 1 | Completion ended in error |
| msg_illegal | input | 1 | Completion was an illegal command |
| msg_busy | input | 1 | Completion answered with busy status |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | SA_W | Host word select |
| host_wdata | input | WORD_W | Host write data |
| host_rdata | output | WORD_W | Read data, one cycle after the strobe |
| ptr_b | output | 1 | Pointer B selected for the current message |

## Verification
`host_rdata` is registered. It is due at the first falling edge after the clock edge that sees `host_rd`, so the monitor compares a queued expectation exactly there. `ptr_b` follows the subaddress latched at the start edge and is sampled at the falling edge after it. Select and activity updates are visible on the clock edge that takes the done. A control write reaches the acknowledge bit two edges later, so the bench waits three cycles after any control write before it reads the word back.

// File: rtl/pp_desc_pkg.sv
package pp_desc_pkg;
    localparam int WORD_W   = 8;
    localparam int BIT_EN   = 0;
    localparam int BIT_STOP = 1;
    localparam int BIT_ACK  = 4;
    localparam int BIT_SEL  = 5;
    localparam int BIT_BC   = 6;
    localparam int BIT_ACT  = 7;

    typedef enum logic [1:0] {SA_OFF, SA_RUN, SA_HALT} sa_state_t;
    typedef enum logic {MSG_IDLE, MSG_BUSY} msg_state_t;
endpackage

// File: rtl/pp_msg_seq.sv
module pp_msg_seq #(
    parameter int SA_W = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            soft_rst,
    input  logic            msg_start,
    input  logic [SA_W-1:0] msg_sa,
    input  logic            msg_tx,
    input  logic            msg_done,
    output logic            start_fire,
    output logic            done_fire,
    output logic            active,
    output logic [SA_W-1:0] cur_sa,
    output logic            cur_tx
);
    import pp_desc_pkg::*;

    msg_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MSG_IDLE: if (msg_start) state_d = MSG_BUSY;
            MSG_BUSY: if (msg_done)  state_d = MSG_IDLE;
            default:  state_d = MSG_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        state_q <= MSG_IDLE;
        else if (soft_rst) state_q <= MSG_IDLE;
        else               state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_sa <= '0;
            cur_tx <= 1'b0;
        end else if (soft_rst) begin
            cur_sa <= '0;
            cur_tx <= 1'b0;
        end else if (start_fire) begin
            cur_sa <= msg_sa;
            cur_tx <= msg_tx;
        end
    end

    always_comb begin
        start_fire = (state_q == MSG_IDLE) && msg_start;
        done_fire  = (state_q == MSG_BUSY) && msg_done;
        active     = (state_q == MSG_BUSY);
    end

    assert_done_ends_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done_fire && !soft_rst) |=> !active);
endmodule

// File: rtl/pp_sa_cell.sv
module pp_sa_cell
    import pp_desc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              wr_hit,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              rd_hit,
    input  logic              bc_set,
    input  logic              done_hit,
    input  logic              done_tx,
    input  logic              done_clean,
    input  logic              quiet,
    output logic [WORD_W-1:0] word,
    output logic              ptr_b
);
    sa_state_t state_q, state_d;
    logic en_q, stop_q, sel_q, bc_q, act_q;
    logic flip;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SA_OFF: begin
                if (quiet && en_q) state_d = stop_q ? SA_HALT : SA_RUN;
            end
            SA_RUN: begin
                if (quiet) begin
                    if (!en_q)      state_d = SA_OFF;
                    else if (stop_q) state_d = SA_HALT;
                end
            end
            SA_HALT: begin
                if (quiet) begin
                    if (!en_q)       state_d = SA_OFF;
                    else if (!stop_q) state_d = SA_RUN;
                end
            end
            default: state_d = SA_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        state_q <= SA_OFF;
        else if (soft_rst) state_q <= SA_OFF;
        else               state_q <= state_d;
    end

    assign flip = done_hit && done_tx && done_clean && (state_q == SA_RUN);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= 1'b0; stop_q <= 1'b0; sel_q <= 1'b0; bc_q <= 1'b0; act_q <= 1'b0;
        end else if (soft_rst) begin
            en_q <= 1'b0; stop_q <= 1'b0; sel_q <= 1'b0; bc_q <= 1'b0; act_q <= 1'b0;
        end else begin
            if (wr_hit) begin
                en_q   <= wr_data[BIT_EN];
                stop_q <= wr_data[BIT_STOP];
            end
            if (flip)        sel_q <= ~sel_q;
            if (bc_set)      bc_q  <= 1'b1;
            if (done_hit)    act_q <= 1'b1;
            else if (rd_hit) act_q <= 1'b0;
        end
    end

    always_comb begin
        word           = '0;
        word[BIT_EN]   = en_q;
        word[BIT_STOP] = stop_q;
        word[BIT_ACK]  = (state_q == SA_RUN);
        word[BIT_SEL]  = sel_q;
        word[BIT_BC]   = bc_q;
        word[BIT_ACT]  = act_q;
        ptr_b          = en_q & sel_q;
    end

    assert_act_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (done_hit && !soft_rst) |=> act_q);
    assert_sel_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done_hit && !done_clean && !soft_rst) |=> $stable(sel_q));
    assert_sel_flip_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (done_hit && done_tx && done_clean && word[BIT_ACK] && !soft_rst) |=> (sel_q != $past(sel_q)));
    assert_ack_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!quiet && !soft_rst) |=> $stable(state_q));
endmodule

// File: rtl/pp_desc_ctrl.sv
module pp_desc_ctrl
    import pp_desc_pkg::*;
#(
    parameter int NUM_SA = 4,
    parameter int SA_W   = (NUM_SA > 1) ? $clog2(NUM_SA) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              bcast_disable,
    input  logic              msg_start,
    input  logic [SA_W-1:0]   msg_sa,
    input  logic              msg_tx,
    input  logic              msg_bcast,
    input  logic              msg_done,
    input  logic              msg_err,
    input  logic              msg_illegal,
    input  logic              msg_busy,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [SA_W-1:0]   host_addr,
    input  logic [WORD_W-1:0] host_wdata,
    output logic [WORD_W-1:0] host_rdata,
    output logic              ptr_b
);
    logic            start_fire, done_fire, active, cur_tx, quiet, done_clean;
    logic [SA_W-1:0] cur_sa;
    logic [WORD_W-1:0] words [NUM_SA];
    logic [NUM_SA-1:0] ptr_vec;
    logic [WORD_W-1:0] rd_word;

    pp_msg_seq #(.SA_W(SA_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
        .msg_start(msg_start), .msg_sa(msg_sa), .msg_tx(msg_tx), .msg_done(msg_done),
        .start_fire(start_fire), .done_fire(done_fire), .active(active),
        .cur_sa(cur_sa), .cur_tx(cur_tx)
    );

    assign quiet      = !active && !msg_start;
    assign done_clean = !msg_err && !msg_illegal && !msg_busy;

    for (genvar i = 0; i < NUM_SA; i++) begin : g_sa
        pp_sa_cell u_cell (
            .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
            .wr_hit(host_wr && (host_addr == i[SA_W-1:0])),
            .wr_data(host_wdata),
            .rd_hit(host_rd && (host_addr == i[SA_W-1:0])),
            .bc_set(start_fire && msg_bcast && !bcast_disable && (msg_sa == i[SA_W-1:0])),
            .done_hit(done_fire && (cur_sa == i[SA_W-1:0])),
            .done_tx(cur_tx),
            .done_clean(done_clean),
            .quiet(quiet),
            .word(words[i]),
            .ptr_b(ptr_vec[i])
        );
    end

    always_comb begin
        rd_word = '0;
        ptr_b   = 1'b0;
        for (int i = 0; i < NUM_SA; i++) begin
            if (host_addr == i[SA_W-1:0]) rd_word = words[i];
            if (cur_sa == i[SA_W-1:0])    ptr_b   = ptr_vec[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        host_rdata <= '0;
        else if (soft_rst) host_rdata <= '0;
        else if (host_rd)  host_rdata <= rd_word;
    end

    assert_rdata_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_rd && !soft_rst) |=> $stable(host_rdata));
endmodule

// File: tb/pp_desc_ctrl_bench.sv
module pp_desc_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NS = 4;
    localparam int AW = 2;

    logic clk = 0, rst_n = 0, soft_rst = 0, bcast_disable = 0;
    logic msg_start = 0, msg_tx = 0, msg_bcast = 0, msg_done = 0;
    logic msg_err = 0, msg_illegal = 0, msg_busy = 0;
    logic host_wr = 0, host_rd = 0;
    logic [AW-1:0] msg_sa = 0, host_addr = 0;
    logic [7:0] host_wdata = 0, host_rdata;
    logic ptr_b;

    int checks = 0, errors = 0;
    logic [7:0] exp_q[$];
    string tag_q[$];
    logic rd_d = 0;
    bit m_en[NS], m_stop[NS], m_ack[NS], m_sel[NS], m_bc[NS], m_act[NS];

    always #(CLK_PERIOD/2) clk = ~clk;

    pp_desc_ctrl #(.NUM_SA(NS)) u_pp_desc_ctrl (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .bcast_disable(bcast_disable),
        .msg_start(msg_start), .msg_sa(msg_sa), .msg_tx(msg_tx), .msg_bcast(msg_bcast),
        .msg_done(msg_done), .msg_err(msg_err), .msg_illegal(msg_illegal), .msg_busy(msg_busy),
        .host_wr(host_wr), .host_rd(host_rd), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .ptr_b(ptr_b)
    );

    function automatic logic [7:0] model_word(int s);
        return {m_act[s], m_bc[s], m_sel[s], m_ack[s], 2'b00, m_stop[s], m_en[s]};
    endfunction

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    always @(posedge clk) rd_d <= host_rd;

    always @(negedge clk) begin
        if (rd_d) begin
            logic [7:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(t, host_rdata, e);
        end
    end

    task automatic clear_model();
        for (int s = 0; s < NS; s++) begin
            m_en[s] = 0; m_stop[s] = 0; m_ack[s] = 0; m_sel[s] = 0; m_bc[s] = 0; m_act[s] = 0;
        end
    endtask

    task automatic rd(int s, string tag);
        host_rd = 1; host_addr = AW'(s);
        exp_q.push_back(model_word(s)); tag_q.push_back(tag);
        m_act[s] = 0;
        @(negedge clk); host_rd = 0;
        @(negedge clk);
    endtask

    task automatic wr(int s, logic [7:0] d);
        host_wr = 1; host_addr = AW'(s); host_wdata = d;
        m_en[s] = d[0]; m_stop[s] = d[1];
        @(negedge clk); host_wr = 0;
        repeat (3) @(negedge clk);
        m_ack[s] = m_en[s] && !m_stop[s];
    endtask

    task automatic msg_begin(int s, bit tx, bit bc);
        msg_start = 1; msg_sa = AW'(s); msg_tx = tx; msg_bcast = bc;
        if (bc && !bcast_disable) m_bc[s] = 1;
        @(negedge clk); msg_start = 0; msg_bcast = 0;
    endtask

    task automatic msg_end(int s, bit tx, bit er, bit il, bit bz, bit with_rd);
        msg_done = 1; msg_err = er; msg_illegal = il; msg_busy = bz;
        if (with_rd) begin
            host_rd = 1; host_addr = AW'(s);
            exp_q.push_back(model_word(s)); tag_q.push_back("R3 read with completion");
        end
        m_act[s] = 1;
        if (tx && !er && !il && !bz && m_ack[s]) m_sel[s] = !m_sel[s];
        @(negedge clk);
        msg_done = 0; msg_err = 0; msg_illegal = 0; msg_busy = 0; host_rd = 0;
        @(negedge clk);
    endtask

    task automatic msg(int s, bit tx, bit er, bit il, bit bz, bit exp_ptr, string tag);
        msg_begin(s, tx, 0);
        check(tag, {7'b0, ptr_b}, {7'b0, exp_ptr});
        msg_end(s, tx, er, il, bz, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog actual timeout expected finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        clear_model();
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        for (int s = 0; s < NS; s++) rd(s, "R1 reset word");
        check("R1 reset ptr_b", {7'b0, ptr_b}, 8'h00);
        // R11 only bits 0,1 writable
        wr(1, 8'hFF);
        rd(1, "R11 write ignored on read-only bits");
        // R6 enable with no stop raises ack
        wr(1, 8'h01);
        rd(1, "R6 ack raised");
        // R4 clean transmit toggles select
        msg(1, 1, 0, 0, 0, 0, "R4 first message uses A");
        rd(1, "R4 select toggled");
        msg(1, 1, 0, 0, 0, 1, "R4 second message uses B");
        rd(1, "R4 select toggled back");
        // R5 error, illegal, busy, receive: no toggle; R2 activity set
        msg(1, 1, 1, 0, 0, 0, "R5 error message ptr");
        rd(1, "R5 hold after error R2");
        msg(1, 1, 0, 1, 0, 0, "R5 illegal message ptr");
        rd(1, "R5 hold after illegal");
        msg(1, 1, 0, 0, 1, 0, "R5 busy message ptr");
        rd(1, "R5 hold after busy");
        msg(1, 0, 0, 0, 0, 0, "R5 receive message ptr");
        rd(1, "R2 receive sets activity");
        // R3 read clears activity
        rd(1, "R3 activity cleared by read");
        // R8 paused: select sticks, ptr follows select
        msg(1, 1, 0, 0, 0, 0, "R4 toggle before pause");
        wr(1, 8'h03);
        rd(1, "R6 stop drops ack");
        msg(1, 1, 0, 0, 0, 1, "R8 paused uses select B");
        msg(1, 1, 0, 0, 0, 1, "R8 paused still B");
        rd(1, "R8 select held while paused");
        wr(1, 8'h01);
        rd(1, "R6 ack raised again");
        // R7 stop during message waits for the boundary
        msg_begin(1, 1, 0);
        host_wr = 1; host_addr = 1; host_wdata = 8'h03; m_stop[1] = 1;
        @(negedge clk); host_wr = 0;
        repeat (3) @(negedge clk);
        rd(1, "R7 ack held during message");
        msg_end(1, 1, 0, 0, 0, 0);
        repeat (3) @(negedge clk);
        m_ack[1] = 0;
        rd(1, "R7 ack dropped after done");
        // R10 disabled subaddress forces pointer A
        wr(2, 8'h01);
        msg(2, 1, 0, 0, 0, 0, "R4 sa2 toggle");
        wr(2, 8'h00);
        msg(2, 1, 0, 0, 0, 0, "R10 disabled gives pointer A");
        rd(2, "R10 sa2 word");
        // R9 broadcast
        msg_begin(3, 1, 1); msg_end(3, 1, 0, 1, 0, 0);
        rd(3, "R9 broadcast flag set");
        bcast_disable = 1;
        msg_begin(0, 1, 1); msg_end(0, 1, 0, 1, 0, 0);
        rd(0, "R9 broadcast disabled");
        bcast_disable = 0;
        // R3 read coinciding with completion
        msg_begin(3, 0, 0);
        msg_end(3, 0, 0, 0, 0, 1);
        rd(3, "R3 set wins over read");
        // R12 soft reset
        soft_rst = 1; @(negedge clk); soft_rst = 0; @(negedge clk);
        clear_model();
        for (int s = 0; s < NS; s++) rd(s, "R12 soft reset word");
        check("R12 soft reset ptr_b", {7'b0, ptr_b}, 8'h00);
        repeat (2) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule